// File: doc/BRIEF.md
# Transition-Triggered Memory Standby Controller

This block wraps a small synchronous storage array and keeps it asleep for as long as nothing on its request inputs moves. Every clock it compares the address, write data and the two request strobes against registered copies of their values from the previous clock. When it sees a difference while selected, the array wakes for one cycle and serves the request held in those copies. Read data is captured into an output register and a one-cycle valid pulse is raised. The block then drops back to standby without any command from outside.

The chip-select input overrides the detector. While it is low the array stays asleep and ignores every request, however busy the inputs are. After select is raised again, the first wake has one extra preparation cycle before the access. That wake starts on the select edge itself, even if no other input moves. Standby is shown on a status output; the array enable is internal. Captured read data stays on the output through standby until another read replaces it.

Top module: `tsb_memctl`

## Requirements
- R1: While reset is high and in the first cycle after it, standby is 1, rvalid is 0 and rdata is all zeros. All storage words are cleared to zero.
- R2: While selected, with all request inputs unchanged and no pending reselect wake, standby stays 1 and rvalid stays 0.
- R3: While selected and after the first wake following reselect, a change on any of addr, wdata, rd_req or wr_req that is sampled at a clock edge drives standby to 0 after that edge. Standby is 1 again after the next edge, provided the inputs did not change again.
- R4: A read request (rd_req = 1) raised at the same time as an address sets rdata to the word stored at that address. The new rdata is visible after the second clock edge that follows the change.
- R5: rdata keeps its value in every cycle in which rvalid is 0.
- R6: While chip_sel is low, standby is 1 and rvalid is 0 after every edge. A write requested while deselected does not change storage.
- R7: The first wake after chip_sel rises keeps standby at 0 for two cycles, not one. It starts on the rising select edge even when no other input changes. A read in that wake delivers rdata and rvalid after the third edge.
- R8: A write request (wr_req = 1) stores wdata at addr during the wake cycle. When rd_req and wr_req are both 1 in the same access, rdata returns the word as it was before that write.
- R9: An input change sampled at the edge that ends a wake cycle keeps the array awake for one more cycle and serves the new request. Requests on consecutive cycles are therefore answered in order, one per cycle.
- R10: rvalid is 1 for exactly the cycle after an access that had rd_req set, and 0 after accesses that carried only a write or no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| chip_sel | input | 1 | Select; low forces standby and blocks accesses |
| addr | input | ADDR_W | Word address of the request |
| wdata | input | DATA_W | Data to store on a write |
| rd_req | input | 1 | Read request level; a change counts as a transition |
| wr_req | input | 1 | Write request level; a change counts as a transition |
| rdata | output | DATA_W | Captured read data, held through standby |
| rvalid | output | 1 | One-cycle pulse: rdata was just updated by a read |
| standby | output | 1 | 1 while the array is asleep |

## Verification
A phase register stuck awake shows at once: standby fails to return to 1 one edge after a single change. A stuck sleep phase shows as a missing rvalid two edges after a read request. A reselect flag that is not set or not cleared changes the wake length by exactly one cycle, so it is caught at the first access after select rises. A write gate or a read latch that uses the wrong cycle's request shows up in rdata on the next read of the same word. That read follows within a few cycles in both the directed sequences and the random mix.

// File: rtl/tsb_pkg.sv
package tsb_pkg;

    typedef enum logic [1:0] {
        PH_SLEEP  = 2'd0,
        PH_PREP   = 2'd1,
        PH_ACCESS = 2'd2
    } phase_t;

    typedef struct packed {
        logic rd;
        logic wr;
    } strobe_t;

    // Next phase of the wake sequencer.
    function automatic phase_t next_phase(phase_t cur, logic sel,
                                          logic changed, logic cold);
        phase_t nxt;
        nxt = cur;
        case (cur)
            PH_SLEEP:  if (changed || cold) nxt = cold ? PH_PREP : PH_ACCESS;
            PH_PREP:   nxt = PH_ACCESS;
            PH_ACCESS: nxt = changed ? PH_ACCESS : PH_SLEEP;
            default:   nxt = PH_SLEEP;
        endcase
        if (!sel) nxt = PH_SLEEP;
        return nxt;
    endfunction

endpackage

// File: rtl/tsb_detect.sv
module tsb_detect
    import tsb_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  strobe_t       strb,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output strobe_t       strb_q,
    output logic          changed
);

    // Shadow copies follow the inputs every clock, reset or not.
    always_ff @(posedge clk) begin
        addr_q  <= addr;
        wdata_q <= wdata;
        strb_q  <= strb;
    end

    assign changed = (addr != addr_q) || (wdata != wdata_q) || (strb != strb_q);

endmodule

// File: rtl/tsb_seq.sv
module tsb_seq
    import tsb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sel,
    input  logic   changed,
    output phase_t phase
);

    logic cold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_SLEEP;
            cold_q <= 1'b1;
        end else begin
            phase <= next_phase(phase, sel, changed, cold_q);
            if (!sel)
                cold_q <= 1'b1;
            else if (phase == PH_PREP)
                cold_q <= 1'b0;
        end
    end

endmodule

// File: rtl/tsb_array.sv
module tsb_array
    import tsb_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          sel,
    input  logic [AW-1:0] addr_q,
    input  logic [DW-1:0] wdata_q,
    input  strobe_t       strb_q,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic          go;

    assign go = en && sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (go && strb_q.wr) begin
            mem[addr_q] <= wdata_q;
        end
    end

    // Read-first: the latch samples the word before this cycle's write lands.
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= go && strb_q.rd;
            if (go && strb_q.rd) rdata <= mem[addr_q];
        end
    end

endmodule

// File: rtl/tsb_memctl.sv
module tsb_memctl
    import tsb_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_req,
    input  logic              wr_req,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              standby
);

    strobe_t             strb, strb_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic                changed;
    phase_t              phase;

    assign strb = '{rd: rd_req, wr: wr_req};

    tsb_detect #(.AW(ADDR_W), .DW(DATA_W)) u_detect (
        .clk     (clk),
        .addr    (addr),
        .wdata   (wdata),
        .strb    (strb),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .strb_q  (strb_q),
        .changed (changed)
    );

    tsb_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .sel     (chip_sel),
        .changed (changed),
        .phase   (phase)
    );

    tsb_array #(.AW(ADDR_W), .DW(DATA_W)) u_array (
        .clk     (clk),
        .rst     (rst),
        .en      (phase == PH_ACCESS),
        .sel     (chip_sel),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .strb_q  (strb_q),
        .rdata   (rdata),
        .rvalid  (rvalid)
    );

    assign standby = (phase == PH_SLEEP);

endmodule

// File: rtl/tsb_memctl_chk.sv
module tsb_memctl_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              chip_sel,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              rvalid,
    input logic              standby
);

    assert_deselect_sleep_R6: assert property (@(posedge clk) disable iff (rst)
        !chip_sel |=> standby);

    assert_deselect_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !chip_sel |=> !rvalid);

    assert_valid_after_wake_R10: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> $past(!standby));

    assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !rvalid |-> $stable(rdata));

    assert_reselect_wakes_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(chip_sel) |=> !standby);

    assert_addr_change_wakes_R3: assert property (@(posedge clk) disable iff (rst)
        (chip_sel && standby && (addr != $past(addr))) |=> !standby);

endmodule

bind tsb_memctl tsb_memctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .chip_sel (chip_sel),
    .addr     (addr),
    .rdata    (rdata),
    .rvalid   (rvalid),
    .standby  (standby)
);

// File: tb/tsb_memctl_bench.sv
`timescale 1ns/1ps
module tsb_memctl_bench;

    localparam int AW = 4;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          chip_sel;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic          rd_req;
    logic          wr_req;
    logic [DW-1:0] rdata;
    logic          rvalid;
    logic          standby;

    logic [DW-1:0] ref_mem [DEPTH];
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tsb_memctl #(.ADDR_W(AW), .DATA_W(DW)) u_tsb_memctl (
        .clk(clk), .rst(rst), .chip_sel(chip_sel), .addr(addr), .wdata(wdata),
        .rd_req(rd_req), .wr_req(wr_req), .rdata(rdata), .rvalid(rvalid),
        .standby(standby)
    );

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [DW-1:0] model_read(logic [AW-1:0] a);
        return ref_mem[a];
    endfunction

    // Issue one request from idle strobes, check timing and data, then release.
    task automatic op(logic [AW-1:0] a, logic [DW-1:0] d, logic r, logic w, bit cold);
        logic [DW-1:0] exp_rd;
        logic [DW-1:0] held;
        exp_rd = model_read(a);
        held   = rdata;
        addr = a; wdata = d; rd_req = r; wr_req = w;
        if (cold) begin
            tick();
            chk(!standby, "R7 extra wake cycle", standby, 0);
        end
        tick();
        chk(!standby, cold ? "R7 access cycle" : "R3 wake on change", standby, 0);
        tick();
        chk(standby, "R3 back to standby", standby, 1);
        chk(rvalid == r, "R10 rvalid follows read", rvalid, r);
        if (r) chk(rdata == exp_rd, (r && w) ? "R8 read-first" : "R4 read data", rdata, exp_rd);
        else   chk(rdata == held, "R5 rdata held on write", rdata, held);
        if (w) ref_mem[a] = d;
        held = rdata;
        rd_req = 0; wr_req = 0;
        tick();
        chk(!standby, "R3 strobe release wakes", standby, 0);
        tick();
        chk(standby && !rvalid, "R10 no rvalid without read", {standby, rvalid}, 2'b10);
        chk(rdata == held, "R5 rdata held in standby", rdata, held);
    endtask

    task automatic deselect_phase(int n);
        logic [DW-1:0] held;
        held = rdata;
        chip_sel = 0;
        for (int i = 0; i < n; i++) begin
            addr = AW'($urandom); wdata = DW'($urandom);
            rd_req = 1'($urandom); wr_req = 1'($urandom);
            tick();
            chk(standby && !rvalid, "R6 deselected stays asleep", {standby, rvalid}, 2'b10);
            chk(rdata == held, "R6 rdata untouched when deselected", rdata, held);
        end
        rd_req = 0; wr_req = 0;
        tick();
        chk(standby, "R6 deselected idle", standby, 1);
    endtask

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        rst = 1; chip_sel = 0; addr = '0; wdata = '0; rd_req = 0; wr_req = 0;
        repeat (4) tick();
        chk(standby && !rvalid && rdata == 0, "R1 reset state", {standby, rvalid, rdata}, 10'h200);
        rst = 0;
        tick();
        chk(standby && !rvalid && rdata == 0, "R1 after reset", {standby, rvalid, rdata}, 10'h200);

        // R7: select edge alone wakes for two cycles
        chip_sel = 1;
        tick(); chk(!standby, "R7 reselect wake 1", standby, 0);
        tick(); chk(!standby, "R7 reselect wake 2", standby, 0);
        tick(); chk(standby && !rvalid, "R7 back asleep", {standby, rvalid}, 2'b10);

        // R2: quiet inputs
        repeat (5) begin
            tick();
            chk(standby && !rvalid, "R2 stable inputs stay asleep", {standby, rvalid}, 2'b10);
        end

        // R8 / R4 directed
        op(4'h3, 8'h5a, 0, 1, 0);
        op(4'h3, 8'h00, 1, 0, 0);
        op(4'hf, 8'hc3, 0, 1, 0);
        op(4'hf, 8'h77, 1, 1, 0);
        op(4'hf, 8'h00, 1, 0, 0);

        // R6: deselected write is dropped, then R7 cold read
        chip_sel = 0; tick();
        addr = 4'h3; wdata = 8'haa; wr_req = 1; tick();
        chk(standby, "R6 deselected write asleep", standby, 1);
        wr_req = 0; tick();
        chip_sel = 1;
        op(4'h3, 8'h00, 1, 0, 1);
        chk(rdata == 8'h5a, "R6 deselected write ignored", rdata, 8'h5a);

        // R9 back-to-back reads
        addr = 4'h3; rd_req = 1;
        tick(); chk(!standby, "R9 first wake", standby, 0);
        addr = 4'hf;
        tick();
        chk(rvalid && rdata == ref_mem[3] && !standby, "R9 first served, still awake",
            {standby, rvalid, rdata}, {2'b01, ref_mem[3]});
        tick();
        chk(rvalid && rdata == ref_mem[15] && standby, "R9 second served",
            {standby, rvalid, rdata}, {2'b11, ref_mem[15]});
        rd_req = 0; tick(); tick();
        chk(standby && !rvalid, "R9 settle", {standby, rvalid}, 2'b10);

        // Random mix
        for (int it = 0; it < 300; it++) begin
            int kind;
            kind = int'($urandom % 3);
            if (($urandom % 10) == 0) begin
                deselect_phase(1 + int'($urandom % 5));
                chip_sel = 1;
                op(AW'($urandom), DW'($urandom), 1, kind == 2, 1);
            end else begin
                op(AW'($urandom), DW'($urandom), kind != 1, kind != 0, 0);
            end
        end

        done = 1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule